// File: doc/BRIEF.md
# Multi-View Aliased Register File

This block holds sixteen 16-bit general registers. The same storage can be reached through four overlapping views. Single words cover all sixteen registers. 32-bit pairs start on an even index. 64-bit quads start on an index that is a multiple of four. The 8-bit byte view covers only the first eight words. A write through any view changes the underlying words at the clock edge, so every overlapping view sees the new value from the next cycle on. The file serves as the operand store of a 16-bit processor datapath. Register 15 doubles as the primary stack pointer and is read like any other word.

There is one write port and two independent read ports. Each port carries a 2-bit view selector (0 byte, 1 word, 2 pair, 3 quad), a 4-bit specifier and a 64-bit data bus. Narrow values sit in the least significant bits of the bus. Reads are combinational. Writes take effect at the rising clock edge. A specifier that the chosen view cannot name raises a flag and blocks the write.

Top module: `alias_regfile`

## Requirements
- R1: While `rst_n` is low, all sixteen registers are cleared to zero, and after reset every read through every view returns zero.
- R2: A word write (view 1) with specifier n in 0..15 replaces register n with `wr_data[15:0]`. A word read returns register n in bits 15:0 with bits 63:16 zero. This includes register 15.
- R3: A pair write (view 2) with an even specifier n stores `wr_data[31:16]` in register n+1 and `wr_data[15:0]` in register n in the same cycle. A pair read returns {register n+1, register n} in bits 31:0 with bits 63:32 zero.
- R4: A quad write (view 3) with specifier b in {0,4,8,12} stores `wr_data[16k+15:16k]` in register b+k for k = 0..3 in the same cycle. A quad read returns the same arrangement.
- R5: In byte view (view 0), specifier bit 3 selects the high byte when 0 and the low byte when 1, and bits 2:0 name register 0..7. A byte write stores `wr_data[7:0]` into only those 8 bits. A byte read returns them in bits 7:0 with the rest zero.
- R6: A write with an odd pair specifier or a quad specifier not a multiple of four drives `wr_illegal` high while `wr_en` is high and leaves all registers unchanged.
- R7: Reads are combinational. A read of a location being written in the same cycle returns its old contents, and the new value appears after the clock edge.
- R8: A read with an odd pair specifier or a quad specifier not a multiple of four returns all zeros.
- R9: With `wr_en` low, no register changes, whatever the other write inputs carry.
- R10: The two read ports select and return data independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the file |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | Write view: 0 byte, 1 word, 2 pair, 3 quad |
| wr_spec | input | 4 | Write register specifier |
| wr_data | input | 64 | Write data, least significant bits used for narrow views |
| wr_illegal | output | 1 | Write specifier not valid for the write view |
| rd0_size | input | 2 | Read port 0 view |
| rd0_spec | input | 4 | Read port 0 specifier |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd1_size | input | 2 | Read port 1 view |
| rd1_spec | input | 4 | Read port 1 specifier |
| rd1_data | output | 64 | Read port 1 data, zero-extended |

## Verification
The aliasing is tried with write-then-read pairs that cross views. A byte is written, then its word is read. Pairs and quads are written, then single words or other pairs inside them are read. This shows whether each view maps to the right words and byte lanes, and whether halves come out swapped or shifted. Byte writes to the high and then the low half of one word tell apart a correct single-lane update from one that clobbers the neighbouring byte. Misaligned pair and quad specifiers on both the write and read sides separate correct blocking from writes that silently round to an aligned base. Same-cycle write/read and mid-run reset patterns confirm old-value reads and a full clear.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

   // View selector shared by the write port and both read ports
   typedef enum logic [1:0] {
      VIEW_BYTE = 2'd0,
      VIEW_WORD = 2'd1,
      VIEW_PAIR = 2'd2,
      VIEW_QUAD = 2'd3
   } view_e;

   // Number of words joined by the widest view
   localparam int QUAD_WORDS = 4;

endpackage

// File: rtl/alias_rf_wdec.sv
// Write-side specifier decode: per-word byte-lane enables and legality.
module alias_rf_wdec
   import alias_rf_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int BYTE_REGS = 8,
   localparam int SPEC_W   = $clog2(NUM_WORDS),
   localparam int BIDX_W   = $clog2(BYTE_REGS)
) (
   input  logic                 wr_en,
   input  view_e                wr_size,
   input  logic [SPEC_W-1:0]    wr_spec,
   output logic [NUM_WORDS-1:0] lane_lo,
   output logic [NUM_WORDS-1:0] lane_hi,
   output logic                 illegal
);

   logic legal;
   logic go;
   logic is_byte;
   logic pick_low;

   always_comb begin
      unique case (wr_size)
         VIEW_PAIR: legal = ~wr_spec[0];
         VIEW_QUAD: legal = (wr_spec[1:0] == 2'b00);
         default:   legal = 1'b1;
      endcase
   end

   assign go       = wr_en & legal;
   assign illegal  = wr_en & ~legal;
   assign is_byte  = (wr_size == VIEW_BYTE);
   assign pick_low = wr_spec[SPEC_W-1];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam logic [SPEC_W-1:0] IDX = SPEC_W'(i);
      logic sel_w;
      logic sel_p;
      logic sel_q;
      logic sel_b;
      logic sel;

      assign sel_w = (wr_spec == IDX);
      assign sel_p = (wr_spec[SPEC_W-1:1] == IDX[SPEC_W-1:1]);
      assign sel_q = (wr_spec[SPEC_W-1:2] == IDX[SPEC_W-1:2]);

      if (i < BYTE_REGS) begin : g_bytes
         assign sel_b = (wr_spec[BIDX_W-1:0] == IDX[BIDX_W-1:0]);
      end else begin : g_nobytes
         assign sel_b = 1'b0;
      end

      always_comb begin
         unique case (wr_size)
            VIEW_BYTE: sel = sel_b;
            VIEW_WORD: sel = sel_w;
            VIEW_PAIR: sel = sel_p;
            default:   sel = sel_q;
         endcase
      end

      assign lane_lo[i] = go & sel & (~is_byte |  pick_low);
      assign lane_hi[i] = go & sel & (~is_byte | ~pick_low);
   end

endmodule

// File: rtl/alias_rf_store.sv
// Word storage with independent byte-lane write enables.
module alias_rf_store
   import alias_rf_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   localparam int HALF     = WORD_W / 2,
   localparam int BUS_W    = QUAD_WORDS * WORD_W,
   localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  view_e                wr_size,
   input  logic [BUS_W-1:0]     wr_data,
   input  logic [NUM_WORDS-1:0] lane_lo,
   input  logic [NUM_WORDS-1:0] lane_hi,
   output logic [FLAT_W-1:0]    store_flat
);

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam int PSLOT = i % 2;
      localparam int QSLOT = i % QUAD_WORDS;
      logic [WORD_W-1:0] wval;
      logic [WORD_W-1:0] word_q;

      // Slice of the write bus that belongs to this word in each view
      always_comb begin
         unique case (wr_size)
            VIEW_BYTE: wval = {2{wr_data[HALF-1:0]}};
            VIEW_WORD: wval = wr_data[WORD_W-1:0];
            VIEW_PAIR: wval = wr_data[PSLOT*WORD_W +: WORD_W];
            default:   wval = wr_data[QSLOT*WORD_W +: WORD_W];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else begin
            if (lane_lo[i]) word_q[HALF-1:0]      <= wval[HALF-1:0];
            if (lane_hi[i]) word_q[WORD_W-1:HALF] <= wval[WORD_W-1:HALF];
         end
      end

      assign store_flat[i*WORD_W +: WORD_W] = word_q;
   end

endmodule

// File: rtl/alias_rf_rview.sv
// One combinational read port: view selection and zero extension.
module alias_rf_rview
   import alias_rf_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   parameter int BYTE_REGS = 8,
   localparam int SPEC_W   = $clog2(NUM_WORDS),
   localparam int BIDX_W   = $clog2(BYTE_REGS),
   localparam int HALF     = WORD_W / 2,
   localparam int BUS_W    = QUAD_WORDS * WORD_W,
   localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
   input  logic [FLAT_W-1:0] store_flat,
   input  view_e             rd_size,
   input  logic [SPEC_W-1:0] rd_spec,
   output logic [BUS_W-1:0]  rd_data
);

   logic [WORD_W-1:0] words [NUM_WORDS];
   logic [SPEC_W-1:0] byte_idx;
   logic [SPEC_W-1:0] pair_hi;
   logic [WORD_W-1:0] byte_word;

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_unpack
      assign words[i] = store_flat[i*WORD_W +: WORD_W];
   end

   assign byte_idx  = SPEC_W'(rd_spec[BIDX_W-1:0]);
   assign pair_hi   = {rd_spec[SPEC_W-1:1], 1'b1};
   assign byte_word = words[byte_idx];

   always_comb begin
      rd_data = '0;
      unique case (rd_size)
         VIEW_BYTE: begin
            if (rd_spec[SPEC_W-1]) rd_data[HALF-1:0] = byte_word[HALF-1:0];
            else                   rd_data[HALF-1:0] = byte_word[WORD_W-1:HALF];
         end
         VIEW_WORD: begin
            rd_data[WORD_W-1:0] = words[rd_spec];
         end
         VIEW_PAIR: begin
            if (!rd_spec[0]) rd_data[2*WORD_W-1:0] = {words[pair_hi], words[rd_spec]};
         end
         default: begin
            if (rd_spec[1:0] == 2'b00) begin
               for (int k = 0; k < QUAD_WORDS; k++) begin
                  rd_data[k*WORD_W +: WORD_W] = words[{rd_spec[SPEC_W-1:2], 2'(k)}];
               end
            end
         end
      endcase
   end

endmodule

// File: rtl/alias_regfile.sv
// Register file with byte, word, pair and quad views over shared storage.
module alias_regfile
   import alias_rf_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   parameter int BYTE_REGS = 8,
   localparam int SPEC_W   = $clog2(NUM_WORDS),
   localparam int BUS_W    = QUAD_WORDS * WORD_W,
   localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_size,
   input  logic [SPEC_W-1:0] wr_spec,
   input  logic [BUS_W-1:0]  wr_data,
   output logic              wr_illegal,
   input  logic [1:0]        rd0_size,
   input  logic [SPEC_W-1:0] rd0_spec,
   output logic [BUS_W-1:0]  rd0_data,
   input  logic [1:0]        rd1_size,
   input  logic [SPEC_W-1:0] rd1_spec,
   output logic [BUS_W-1:0]  rd1_data
);

   // Elaboration-time parameter checks
   if (NUM_WORDS != (1 << SPEC_W) || NUM_WORDS < QUAD_WORDS) begin : g_bad_words
      $error("NUM_WORDS must be a power of two and at least one quad");
   end
   if (2 * BYTE_REGS != NUM_WORDS) begin : g_bad_bytes
      $error("byte specifier must share the word specifier width");
   end
   if (WORD_W % 2 != 0 || WORD_W < 2) begin : g_bad_width
      $error("WORD_W must split into two equal bytes");
   end

   logic [NUM_WORDS-1:0] lane_lo;
   logic [NUM_WORDS-1:0] lane_hi;
   logic [FLAT_W-1:0]    store_flat;

   alias_rf_wdec #(
      .NUM_WORDS (NUM_WORDS),
      .BYTE_REGS (BYTE_REGS)
   ) u_wdec (
      .wr_en   (wr_en),
      .wr_size (view_e'(wr_size)),
      .wr_spec (wr_spec),
      .lane_lo (lane_lo),
      .lane_hi (lane_hi),
      .illegal (wr_illegal)
   );

   alias_rf_store #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_size    (view_e'(wr_size)),
      .wr_data    (wr_data),
      .lane_lo    (lane_lo),
      .lane_hi    (lane_hi),
      .store_flat (store_flat)
   );

   alias_rf_rview #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .BYTE_REGS (BYTE_REGS)
   ) u_rd0 (
      .store_flat (store_flat),
      .rd_size    (view_e'(rd0_size)),
      .rd_spec    (rd0_spec),
      .rd_data    (rd0_data)
   );

   alias_rf_rview #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .BYTE_REGS (BYTE_REGS)
   ) u_rd1 (
      .store_flat (store_flat),
      .rd_size    (view_e'(rd1_size)),
      .rd_spec    (rd1_spec),
      .rd_data    (rd1_data)
   );

endmodule

// File: rtl/alias_rf_chk.sv
// Property checker for alias_regfile, attached by bind.
module alias_rf_chk
   import alias_rf_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   parameter int WORD_W    = 16,
   parameter int BYTE_REGS = 8,
   localparam int SPEC_W   = $clog2(NUM_WORDS),
   localparam int BIDX_W   = $clog2(BYTE_REGS),
   localparam int HALF     = WORD_W / 2,
   localparam int BUS_W    = QUAD_WORDS * WORD_W,
   localparam int FLAT_W   = NUM_WORDS * WORD_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_size,
   input logic [SPEC_W-1:0] wr_spec,
   input logic [BUS_W-1:0]  wr_data,
   input logic              wr_illegal,
   input logic [1:0]        rd0_size,
   input logic [SPEC_W-1:0] rd0_spec,
   input logic [BUS_W-1:0]  rd0_data,
   input logic [FLAT_W-1:0] store_flat
);

   // R1: a clock edge seen in reset leaves the file cleared
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (store_flat == '0));

   // R2: a word write lands in the named register
   assert_word_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd1) |=>
      (store_flat[int'($past(wr_spec))*WORD_W +: WORD_W] == $past(wr_data[WORD_W-1:0])));

   // R3: an aligned pair write lands in both words
   assert_pair_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd2 && !wr_spec[0]) |=>
      (store_flat[int'($past(wr_spec))*WORD_W +: 2*WORD_W] == $past(wr_data[2*WORD_W-1:0])));

   // R5: a low-byte write leaves the high byte of that word alone
   assert_byte_keeps_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd0 && wr_spec[SPEC_W-1]) |=>
      (store_flat[int'($past(wr_spec[BIDX_W-1:0]))*WORD_W + HALF +: HALF] ==
       $past(store_flat[int'(wr_spec[BIDX_W-1:0])*WORD_W + HALF +: HALF])));

   // R6: a flagged write changes nothing
   assert_illegal_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_illegal |=> $stable(store_flat));

   // R6: misaligned pair write raises the flag
   assert_pair_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 2'd2 && wr_spec[0]) |-> wr_illegal);

   // R9: no write request, no change
   assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(store_flat));

   // R8: misaligned quad read returns zero
   assert_bad_quad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_size == 2'd3 && rd0_spec[1:0] != 2'b00) |-> (rd0_data == '0));

endmodule

bind alias_regfile alias_rf_chk #(
   .NUM_WORDS (NUM_WORDS),
   .WORD_W    (WORD_W),
   .BYTE_REGS (BYTE_REGS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_size    (wr_size),
   .wr_spec    (wr_spec),
   .wr_data    (wr_data),
   .wr_illegal (wr_illegal),
   .rd0_size   (rd0_size),
   .rd0_spec   (rd0_spec),
   .rd0_data   (rd0_data),
   .store_flat (store_flat)
);

// File: tb/tb_alias_regfile.sv
module tb_alias_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_size = 2'd0;
   logic [3:0]  wr_spec = 4'd0;
   logic [63:0] wr_data = '0;
   logic        wr_illegal;
   logic [1:0]  rd0_size = 2'd1;
   logic [3:0]  rd0_spec = 4'd0;
   logic [63:0] rd0_data;
   logic [1:0]  rd1_size = 2'd1;
   logic [3:0]  rd1_spec = 4'd0;
   logic [63:0] rd1_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   alias_regfile dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_size    (wr_size),
      .wr_spec    (wr_spec),
      .wr_data    (wr_data),
      .wr_illegal (wr_illegal),
      .rd0_size   (rd0_size),
      .rd0_spec   (rd0_spec),
      .rd0_data   (rd0_data),
      .rd1_size   (rd1_size),
      .rd1_spec   (rd1_spec),
      .rd1_data   (rd1_data)
   );

   // Views: 0 byte, 1 word, 2 pair, 3 quad
   typedef struct packed {
      logic [1:0]  wsz;
      logic [3:0]  wsp;
      logic [63:0] wd;
      logic [1:0]  rsz;
      logic [3:0]  rsp;
      logic [63:0] exp;
      logic        ill;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{2'd1, 4'd5,  64'h1234,                2'd1, 4'd5,  64'h1234,                1'b0}, // R2
      '{2'd0, 4'd5,  64'hAB,                  2'd1, 4'd5,  64'hAB34,                1'b0}, // R5 high
      '{2'd0, 4'd13, 64'hCD,                  2'd1, 4'd5,  64'hABCD,                1'b0}, // R5 low
      '{2'd2, 4'd2,  64'h1111_2222,           2'd1, 4'd3,  64'h1111,                1'b0}, // R3
      '{2'd2, 4'd3,  64'hFFFF_FFFF,           2'd2, 4'd2,  64'h1111_2222,           1'b1}, // R6
      '{2'd3, 4'd8,  64'h4444_3333_2222_1111, 2'd2, 4'd10, 64'h4444_3333,           1'b0}, // R4
      '{2'd3, 4'd6,  64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 4'd4,  64'h0000_0000_ABCD_0000, 1'b1}, // R6
      '{2'd1, 4'd15, 64'hFFFE,                2'd1, 4'd15, 64'hFFFE,                1'b0}, // R2 r15
      '{2'd0, 4'd8,  64'h5A,                  2'd0, 4'd8,  64'h5A,                  1'b0}, // R5
      '{2'd1, 4'd14, 64'h00EE,                2'd0, 4'd5,  64'hAB,                  1'b0}, // R5
      '{2'd3, 4'd12, 64'h0102_0304_0506_0708, 2'd1, 4'd15, 64'h0102,                1'b0}, // R4
      '{2'd2, 4'd0,  64'hBEEF_0000,           2'd0, 4'd1,  64'hBE,                  1'b0}  // R3
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] sz, input logic [3:0] sp, input logic [63:0] d,
                           input logic exp_ill, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_size = sz; wr_spec = sp; wr_data = d;
      #1;
      check(req, {63'd0, wr_illegal}, {63'd0, exp_ill});
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic read0(input logic [1:0] sz, input logic [3:0] sp, input logic [63:0] exp,
                        input string req);
      rd0_size = sz; rd0_spec = sp;
      #1;
      check(req, rd0_data, exp);
   endtask

   task automatic all_quads_zero(input string req);
      for (int q = 0; q < 4; q++) begin
         rd0_size = 2'd3; rd0_spec = 4'(q * 4);
         rd1_size = 2'd3; rd1_spec = 4'(q * 4);
         #1;
         check(req, rd0_data, 64'd0);
         check(req, rd1_data, 64'd0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state through every quad on both ports
      all_quads_zero("R1 reset state");
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      all_quads_zero("R1 after release");

      // Vector table walk
      for (int v = 0; v < NVEC; v++) begin
         do_write(VECS[v].wsz, VECS[v].wsp, VECS[v].wd, VECS[v].ill, "R6 flag");
         read0(VECS[v].rsz, VECS[v].rsp, VECS[v].exp, "R2-view table");
      end

      // R7: same-cycle read returns old value, new value after the edge
      @(negedge clk);
      wr_en = 1'b1; wr_size = 2'd1; wr_spec = 4'd5; wr_data = 64'h7777;
      rd0_size = 2'd1; rd0_spec = 4'd5;
      #1;
      check("R7 old value", rd0_data, 64'hABCD);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      check("R7 new value", rd0_data, 64'h7777);

      // R9: disabled write has no effect
      @(negedge clk);
      wr_en = 1'b0; wr_size = 2'd3; wr_spec = 4'd4; wr_data = 64'h1;
      @(posedge clk);
      #1;
      read0(2'd3, 4'd4, 64'h0000_0000_7777_0000, "R9 no write");

      // R8: misaligned reads return zero on both ports
      rd0_size = 2'd2; rd0_spec = 4'd3;
      rd1_size = 2'd3; rd1_spec = 4'd10;
      #1;
      check("R8 odd pair read", rd0_data, 64'd0);
      check("R8 bad quad read", rd1_data, 64'd0);

      // R10: ports independent in one cycle
      rd0_size = 2'd1; rd0_spec = 4'd15;
      rd1_size = 2'd2; rd1_spec = 4'd8;
      #1;
      check("R10 port 0", rd0_data, 64'h0102);
      check("R10 port 1", rd1_data, 64'h2222_1111);

      // R4: quad read of registers 12..15
      read0(2'd3, 4'd12, 64'h0102_0304_0506_0708, "R4 quad read");

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      all_quads_zero("R1 mid-run reset");
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule